// File: doc/BRIEF.md
# Antenna Diversity Dwell Controller

This block runs a short measurement that compares two antennas. A start strobe begins the measurement on antenna 0. The block holds that antenna for a programmed number of dwell steps and then pulses a capture strobe, which samples the signal-strength input. It then moves to antenna 1, dwells for the same time and captures again. One dwell step lasts 20 input clocks, or 40 input clocks when the step-select input is high.

When the diversity enable is high, the block keeps the antenna with the stronger sample. When it is low, the dwells still run so that signal-strength data is collected, but software makes the final choice by pulsing a load strobe together with its antenna bit. A dwell count of zero turns switching off, and in that case a start strobe does nothing.

Top module: `ant_div_dwell`

## Requirements
- R1: After reset, `ant_sel`, `rssi_cap` and `done` are all 0 and no measurement is in progress.
- R2: A `meas_start` pulse while idle, with `dwell_cnt` nonzero, sets `ant_sel` to 0 for exactly `dwell_cnt` x S clocks. S is 20 when `step_sel`=0 and 40 when `step_sel`=1. Next, `rssi_cap` is high for one cycle, the `rssi` value at that edge is stored, and `ant_sel` becomes 1 in the same cycle.
- R3: The second dwell, on antenna 1, lasts the same `dwell_cnt` x S clocks. It ends with a second one-cycle `rssi_cap` pulse.
- R4: A `meas_start` pulse while `dwell_cnt` is 0 is ignored: no `rssi_cap` pulse follows and `ant_sel` keeps its value.
- R5: If `div_en`=1 at the end of the second dwell, `ant_sel` becomes 1 only when the second sample is strictly greater than the first, so a tie selects 0. The new `ant_sel` and a one-cycle `done` pulse appear in the same cycle as the second `rssi_cap`.
- R6: If `div_en`=0 at the end of the second dwell, `ant_sel` stays 1 and `done` stays low. The block then waits for `sw_load`. One cycle after `sw_load`, `ant_sel` equals `sw_ant` and `done` pulses for one cycle.
- R7: A `meas_start` pulse during a measurement is ignored, and the dwell timing does not change.
- R8: `sw_load` during a dwell is ignored. While idle, `sw_load` copies `sw_ant` to `ant_sel` when `div_en`=0 and is ignored when `div_en`=1. A load while idle never pulses `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_en | input | 1 | 1: the block chooses the antenna; 0: software chooses it |
| dwell_cnt | input | 6 | Dwell steps per antenna; 0 turns switching off |
| step_sel | input | 1 | Step length: 0 gives 20 clocks, 1 gives 40 clocks |
| meas_start | input | 1 | Starts a measurement (one-cycle strobe) |
| rssi | input | 8 | Signal-strength value, sampled on a capture |
| sw_ant | input | 1 | Antenna chosen by software |
| sw_load | input | 1 | Applies `sw_ant` (one-cycle strobe) |
| ant_sel | output | 1 | Selected antenna |
| rssi_cap | output | 1 | One-cycle strobe at the end of each dwell |
| done | output | 1 | One-cycle strobe when the final antenna is applied |

## Verification
The assertions assume that `dwell_cnt` and `step_sel` stay constant from a start strobe until the measurement ends. They also assume that `rssi` is valid on the edge where a capture strobe rises. The stimulus changes the configuration only while the block is idle, before it drives the start strobe. It drives the second `rssi` value only after the first capture edge has passed. Random trials draw the count, step length, enable, both samples and the software bit. Directed cases cover a tie, a count of zero and loads sent while idle.

// File: rtl/ant_div_dwell.sv
module ant_div_dwell #(
  parameter int CNT_W  = 6,
  parameter int RSSI_W = 8,
  parameter int STEP_A = 20,
  parameter int STEP_B = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_en,
  input  logic [CNT_W-1:0]  dwell_cnt,
  input  logic              step_sel,
  input  logic              meas_start,
  input  logic [RSSI_W-1:0] rssi,
  input  logic              sw_ant,
  input  logic              sw_load,
  output logic              ant_sel,
  output logic              rssi_cap,
  output logic              done
);
  localparam int PRE_W = $clog2(STEP_B);

  typedef enum logic [1:0] {S_IDLE, S_DW0, S_DW1, S_SW} st_t;

  st_t               st_q;
  logic [PRE_W-1:0]  pre_q;
  logic [CNT_W-1:0]  stp_q;
  logic [RSSI_W-1:0] r0_q;

  wire [PRE_W-1:0] pre_last  = step_sel ? PRE_W'(STEP_B - 1) : PRE_W'(STEP_A - 1);
  wire             dwelling  = (st_q == S_DW0) || (st_q == S_DW1);
  wire             step_end  = (pre_q == pre_last);
  wire             dwell_end = dwelling && step_end && (stp_q == CNT_W'(dwell_cnt - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      pre_q    <= '0;
      stp_q    <= '0;
      r0_q     <= '0;
      ant_sel  <= 1'b0;
      rssi_cap <= 1'b0;
      done     <= 1'b0;
    end else begin
      rssi_cap <= 1'b0;
      done     <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (meas_start && dwell_cnt != '0) begin
            st_q    <= S_DW0;
            ant_sel <= 1'b0;
            pre_q   <= '0;
            stp_q   <= '0;
          end else if (sw_load && !div_en) begin
            ant_sel <= sw_ant;
          end
        end
        S_DW0, S_DW1: begin
          if (dwell_end) begin
            pre_q    <= '0;
            stp_q    <= '0;
            rssi_cap <= 1'b1;
            if (st_q == S_DW0) begin
              r0_q    <= rssi;
              ant_sel <= 1'b1;
              st_q    <= S_DW1;
            end else if (div_en) begin
              ant_sel <= (rssi > r0_q);
              done    <= 1'b1;
              st_q    <= S_IDLE;
            end else begin
              st_q <= S_SW;
            end
          end else if (step_end) begin
            pre_q <= '0;
            stp_q <= stp_q + 1'b1;
          end else begin
            pre_q <= pre_q + 1'b1;
          end
        end
        S_SW: begin
          if (sw_load) begin
            ant_sel <= sw_ant;
            done    <= 1'b1;
            st_q    <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  a_r2_cap_single: assert property (@(posedge clk) disable iff (!rst_n)
    rssi_cap |=> !rssi_cap);

  a_r2_ant0_in_first_dwell: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DW0) |-> !ant_sel);

  a_r3_prescale_bound: assert property (@(posedge clk) disable iff (!rst_n)
    dwelling |-> (pre_q <= pre_last));

  a_r4_zero_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && meas_start && dwell_cnt == '0) |=> (st_q == S_IDLE && !rssi_cap));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_wait_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SW && !sw_load) |=> (!done && ant_sel));

  a_r8_dwell_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DW0 && !dwell_end) |=> (ant_sel == $past(ant_sel)));
endmodule

// File: tb/ant_div_dwell_bench.sv
`timescale 1ns/1ps
module ant_div_dwell_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       div_en = 1'b0;
  logic [5:0] dwell_cnt = '0;
  logic       step_sel = 1'b0;
  logic       meas_start = 1'b0;
  logic [7:0] rssi = '0;
  logic       sw_ant = 1'b0;
  logic       sw_load = 1'b0;
  logic       ant_sel, rssi_cap, done;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ant_div_dwell u_ant_div_dwell (
    .clk(clk), .rst_n(rst_n), .div_en(div_en), .dwell_cnt(dwell_cnt),
    .step_sel(step_sel), .meas_start(meas_start), .rssi(rssi),
    .sw_ant(sw_ant), .sw_load(sw_load), .ant_sel(ant_sel),
    .rssi_cap(rssi_cap), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int dwell_len(input int cnt, input bit sel);
    return cnt * (sel ? 40 : 20);
  endfunction

  function automatic bit pick(input bit en, input int a, input int b, input bit sw);
    if (en) return (b > a);
    return sw;
  endfunction

  task automatic run(input int cnt, input bit sel, input bit en,
                     input int a, input int b, input bit sw);
    int n;
    bit exp_ant;
    n = dwell_len(cnt, sel);
    exp_ant = pick(en, a, b, sw);
    @(negedge clk);
    dwell_cnt = 6'(cnt); step_sel = sel; div_en = en; rssi = 8'(a);
    meas_start = 1'b1;
    @(negedge clk);
    meas_start = 1'b0;
    for (int k = 1; k <= 2 * n; k++) begin
      @(negedge clk);
      if (k == 1) begin sw_ant = 1'b1; sw_load = 1'b1; end
      if (k == 2) begin
        sw_load = 1'b0;
        chk(ant_sel == 1'b0, "R8 dwell load", ant_sel, 0);
      end
      if (k == n - 1) begin
        chk(ant_sel == 1'b0, "R2 ant0 hold", ant_sel, 0);
        chk(rssi_cap == 1'b0, "R2 early cap", rssi_cap, 0);
      end
      if (k == n) begin
        chk(rssi_cap == 1'b1, "R2 first cap", rssi_cap, 1);
        chk(ant_sel == 1'b1, "R2 switch", ant_sel, 1);
        rssi = 8'(b);
      end
      if (k == n + 3) meas_start = 1'b1;
      if (k == n + 4) meas_start = 1'b0;
      if (k == 2 * n - 1) begin
        chk(rssi_cap == 1'b0, "R3 R7 early cap", rssi_cap, 0);
        chk(ant_sel == 1'b1, "R3 ant1 hold", ant_sel, 1);
      end
      if (k == 2 * n) begin
        chk(rssi_cap == 1'b1, "R3 second cap", rssi_cap, 1);
        chk(done == en, "R5 R6 done", done, en);
        if (en) chk(ant_sel == exp_ant, "R5 choice", ant_sel, exp_ant);
        else    chk(ant_sel == 1'b1, "R6 hold ant1", ant_sel, 1);
      end
    end
    @(negedge clk);
    chk(done == 1'b0, "R5 R6 done width", done, 0);
    if (!en) begin
      sw_ant = sw; sw_load = 1'b1;
      @(negedge clk);
      sw_load = 1'b0;
      chk(ant_sel == exp_ant, "R6 sw select", ant_sel, exp_ant);
      chk(done == 1'b1, "R6 sw done", done, 1);
      @(negedge clk);
      chk(done == 1'b0, "R6 done width", done, 0);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    bit caps;
    bit keep;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(ant_sel == 1'b0 && rssi_cap == 1'b0 && done == 1'b0, "R1 reset",
        {ant_sel, rssi_cap, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ant_sel == 1'b0 && rssi_cap == 1'b0 && done == 1'b0, "R1 after release",
        {ant_sel, rssi_cap, done}, 0);

    run(1, 1'b0, 1'b1, 77, 77, 1'b0);
    run(2, 1'b1, 1'b1, 10, 200, 1'b0);
    run(1, 1'b1, 1'b0, 90, 5, 1'b0);
    run(3, 1'b0, 1'b0, 5, 90, 1'b1);

    div_en = 1'b0; sw_ant = 1'b1; sw_load = 1'b1;
    @(negedge clk);
    sw_load = 1'b0;
    chk(ant_sel == 1'b1, "R8 idle load", ant_sel, 1);
    chk(done == 1'b0, "R8 idle no done", done, 0);
    div_en = 1'b1; sw_ant = 1'b0; sw_load = 1'b1;
    @(negedge clk);
    sw_load = 1'b0;
    chk(ant_sel == 1'b1, "R8 idle load ignored", ant_sel, 1);

    dwell_cnt = '0; meas_start = 1'b1;
    @(negedge clk);
    meas_start = 1'b0;
    caps = 1'b0; keep = 1'b1;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (rssi_cap) caps = 1'b1;
      if (!ant_sel) keep = 1'b0;
    end
    chk(!caps, "R4 no capture", caps, 0);
    chk(keep, "R4 antenna kept", keep, 1);

    for (int t = 0; t < 25; t++) begin
      run(int'($urandom_range(63, 1)), 1'($urandom_range(1, 0)),
          1'($urandom_range(1, 0)), int'($urandom_range(255, 0)),
          int'($urandom_range(255, 0)), 1'($urandom_range(1, 0)));
    end
    summary();
  end
endmodule